// File: doc/BRIEF.md
# Timed Self-Programming Command Controller

This block sits between a CPU and a flash programming engine. Software places a command byte in a small control register. The byte holds an enable bit and at most one operation bit. The CPU then raises a single-cycle strobe for a program-memory store or a program-memory load. A store or load takes effect only if its strobe falls inside a short acceptance window that opens when the register is written. When the window closes with no qualifying strobe, the command clears itself. This keeps a stray strobe from starting an unintended flash operation.

An accepted store does one of several things, depending on the operation bit:

- It starts a timed operation: page erase, page write or lock-bit write.
- It issues a one-cycle buffer-load pulse.
- It clears the busy flag of the read-while-write region.

An accepted load with the lock-select bit set issues a fuse/lock read grant. A cycle-counting timer stands in for the flash array. The timer runs for a parameterised number of cycles and then emits a done strobe. While it runs, the enable bit keeps reading one so software can poll for completion. A pending EEPROM write refuses every strobe. An interrupt request shows when the command has finished and interrupts are enabled.

Top module: `spm_cmd_ctrl`

## Requirements
- R1: After a register write with the enable bit (bit 0) set in cycle k, a store strobe is accepted in cycles k+1 to k+4 (STORE_WIN=4) and ignored from cycle k+5 on. An accepted store with no operation bit gives one buf_load_o pulse in the next cycle.
- R2: With the enable bit and the lock-select bit (bit 3) both written in cycle k, a load strobe in cycles k+1 to k+3 (LOAD_WIN=3) gives one lock_rd_o pulse in the next cycle. A later load strobe gives none. A load strobe with bit 3 clear has no effect.
- R3: If no strobe is accepted in the window, cmd_rdata_o bits 4:0 read zero from cycle k+5 on.
- R4: An accepted store with page erase (bit 1) or page write (bit 2) pulses op_start_o for one cycle, starting the cycle after the strobe. In that cycle op_kind_o reads one-hot: erase 3'b001, write 3'b010, lock 3'b100. rww_busy_o (also cmd_rdata_o bit 6) rises in the same cycle.
- R5: rww_busy_o stays set after the operation ends. It clears only in the cycle after an accepted store whose command has the re-enable bit (bit 4) and the enable bit.
- R6: A store or load strobe in a cycle where ee_busy_i is high is ignored, and the window keeps counting.
- R7: A timed operation keeps the enable bit at one for OP_CYCLES cycles after op_start_o. In the cycle after that, op_done_o pulses once and cmd_rdata_o bits 4:0 read zero.
- R8: A store whose command has more than one of bits 1 to 4 set starts nothing, leaves rww_busy_o unchanged and clears bits 4:0.
- R9: irq_o equals interrupt enable (bit 7) AND NOT the enable bit.
- R10: Register writes while a timed operation runs are ignored, the interrupt-enable bit included.
- R11: cmd_rdata_o holds bit 7 interrupt enable, bit 6 rww busy, bit 5 zero, and bits 4:0 as last written or cleared. Reset clears everything.
- R12: An accepted store with lock-select (bit 3) starts a timed operation of kind 3'b100. This operation leaves rww_busy_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr_i | input | 1 | Control register write strobe |
| cmd_wdata_i | input | 8 | Control register write data |
| cmd_rdata_o | output | 8 | Control register read value |
| store_i | input | 1 | Program-memory store instruction strobe |
| load_i | input | 1 | Program-memory load instruction strobe |
| ee_busy_i | input | 1 | EEPROM write in progress |
| op_start_o | output | 1 | One-cycle start pulse to the flash engine |
| op_kind_o | output | 3 | One-hot kind of the started operation |
| op_done_o | output | 1 | One-cycle completion pulse |
| rww_busy_o | output | 1 | Read-while-write region busy, reads blocked |
| buf_load_o | output | 1 | One-cycle page-buffer load pulse |
| lock_rd_o | output | 1 | One-cycle fuse/lock read grant |
| irq_o | output | 1 | Completion interrupt request |

## Verification
The assertions assume the following about the block's inputs:

- Strobes are synchronous single-cycle signals.
- ee_busy_i is a level that may change on any cycle.
- Software writes the register only at instruction pace, never in the same cycle as a strobe.

The stimulus keeps a register write and a strobe out of the same cycle. It writes during an operation only to show that the write is ignored. It raises ee_busy_i only together with a strobe inside an open window, which is where the refusal rule matters.

// File: rtl/spm_cmd_pkg.sv
package spm_cmd_pkg;
   localparam int BIT_EN    = 0;
   localparam int BIT_ERASE = 1;
   localparam int BIT_WRITE = 2;
   localparam int BIT_LOCK  = 3;
   localparam int BIT_REEN  = 4;
   localparam int BIT_RWW   = 6;
   localparam int BIT_IE    = 7;

   typedef enum logic [2:0] {
      OPK_NONE  = 3'b000,
      OPK_ERASE = 3'b001,
      OPK_WRITE = 3'b010,
      OPK_LOCK  = 3'b100
   } op_kind_e;
endpackage

// File: rtl/spm_win.sv
module spm_win #(
   parameter int STORE_WIN = 4,
   parameter int LOAD_WIN  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic disarm_i,
   input  logic store_i,
   input  logic load_i,
   input  logic lock_sel_i,
   input  logic ee_busy_i,
   output logic armed_o,
   output logic st_ok_o,
   output logic ld_ok_o,
   output logic expire_o
);
   localparam int AW = $clog2(STORE_WIN + 1);

   initial begin
      assert (STORE_WIN >= 1) else $error("STORE_WIN must be at least 1");
      assert (LOAD_WIN >= 1 && LOAD_WIN <= STORE_WIN) else $error("LOAD_WIN out of range");
   end

   logic [AW-1:0] age_q;

   assign armed_o  = (age_q != '0);
   assign st_ok_o  = armed_o && store_i && !ee_busy_i;
   assign ld_ok_o  = armed_o && lock_sel_i && load_i && !ee_busy_i && !st_ok_o
                     && (age_q <= AW'(LOAD_WIN));
   assign expire_o = armed_o && !st_ok_o && !ld_ok_o && !arm_i && (age_q == AW'(STORE_WIN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            age_q <= '0;
      else if (st_ok_o || ld_ok_o || disarm_i) age_q <= '0;
      else if (arm_i)                        age_q <= AW'(1);
      else if (expire_o)                     age_q <= '0;
      else if (armed_o)                      age_q <= age_q + AW'(1);
   end

   AST_AGE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      age_q <= AW'(STORE_WIN)); // R1
   AST_LOAD_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_o && load_i && lock_sel_i && !ee_busy_i && !store_i && age_q > AW'(LOAD_WIN)) |-> !ld_ok_o); // R2
endmodule

// File: rtl/spm_op_timer.sv
module spm_op_timer #(
   parameter int OP_CYCLES = 32800
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic last_o,
   output logic done_o
);
   localparam int CW = (OP_CYCLES > 2) ? $clog2(OP_CYCLES) : 1;

   initial begin
      assert (OP_CYCLES >= 2) else $error("OP_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign last_o = busy_o && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt_q  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i && !busy_o) begin
            busy_o <= 1'b1;
            cnt_q  <= CW'(OP_CYCLES - 1);
         end else if (last_o) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
         end else if (busy_o) begin
            cnt_q <= cnt_q - CW'(1);
         end
      end
   end

   AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(busy_o) && !busy_o)); // R7
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !start_i); // R10
endmodule

// File: rtl/spm_cmd_ctrl.sv
module spm_cmd_ctrl
   import spm_cmd_pkg::*;
#(
   parameter int STORE_WIN = 4,
   parameter int LOAD_WIN  = 3,
   parameter int CLK_KHZ   = 8000,
   parameter int OP_US     = 4100,
   parameter bit IRQ_REG   = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_wr_i,
   input  logic [7:0] cmd_wdata_i,
   output logic [7:0] cmd_rdata_o,
   input  logic       store_i,
   input  logic       load_i,
   input  logic       ee_busy_i,
   output logic       op_start_o,
   output logic [2:0] op_kind_o,
   output logic       op_done_o,
   output logic       rww_busy_o,
   output logic       buf_load_o,
   output logic       lock_rd_o,
   output logic       irq_o
);
   localparam int OP_CYCLES = (CLK_KHZ * OP_US + 999) / 1000;

   logic en_q, erase_q, write_q, lock_q, reen_q, ie_q, rww_q;
   logic start_q, buf_q, lrd_q;
   op_kind_e kind_q;

   logic armed, st_ok, ld_ok, expire;
   logic tm_busy, tm_last, tm_done;
   logic wr_ok, multi, timed, start_go;
   logic [2:0] n_ops;
   logic unused_wbits;

   assign unused_wbits = ^cmd_wdata_i[6:5];

   assign n_ops    = 3'(erase_q) + 3'(write_q) + 3'(lock_q) + 3'(reen_q);
   assign multi    = (n_ops > 3'd1);
   assign timed    = !multi && (erase_q || write_q || lock_q);
   assign start_go = st_ok && timed;
   assign wr_ok    = cmd_wr_i && !tm_busy && !st_ok && !ld_ok;

   spm_win #(.STORE_WIN(STORE_WIN), .LOAD_WIN(LOAD_WIN)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (wr_ok && cmd_wdata_i[BIT_EN]),
      .disarm_i  (wr_ok && !cmd_wdata_i[BIT_EN]),
      .store_i   (store_i),
      .load_i    (load_i),
      .lock_sel_i(lock_q),
      .ee_busy_i (ee_busy_i),
      .armed_o   (armed),
      .st_ok_o   (st_ok),
      .ld_ok_o   (ld_ok),
      .expire_o  (expire)
   );

   spm_op_timer #(.OP_CYCLES(OP_CYCLES)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_go),
      .busy_o (tm_busy),
      .last_o (tm_last),
      .done_o (tm_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0; erase_q <= 1'b0; write_q <= 1'b0; lock_q <= 1'b0; reen_q <= 1'b0;
         ie_q <= 1'b0; rww_q <= 1'b0;
         start_q <= 1'b0; buf_q <= 1'b0; lrd_q <= 1'b0;
         kind_q <= OPK_NONE;
      end else begin
         start_q <= 1'b0;
         buf_q   <= 1'b0;
         lrd_q   <= 1'b0;
         if (tm_last || expire || ld_ok || (st_ok && !timed)) begin
            en_q <= 1'b0; erase_q <= 1'b0; write_q <= 1'b0; lock_q <= 1'b0; reen_q <= 1'b0;
         end else if (wr_ok) begin
            en_q    <= cmd_wdata_i[BIT_EN];
            erase_q <= cmd_wdata_i[BIT_ERASE];
            write_q <= cmd_wdata_i[BIT_WRITE];
            lock_q  <= cmd_wdata_i[BIT_LOCK];
            reen_q  <= cmd_wdata_i[BIT_REEN];
         end
         if (wr_ok) ie_q <= cmd_wdata_i[BIT_IE];
         if (ld_ok) lrd_q <= 1'b1;
         if (st_ok) begin
            if (timed) begin
               start_q <= 1'b1;
               kind_q  <= erase_q ? OPK_ERASE : (write_q ? OPK_WRITE : OPK_LOCK);
               if (erase_q || write_q) rww_q <= 1'b1;
            end else if (!multi && reen_q) begin
               rww_q <= 1'b0;
            end else if (!multi) begin
               buf_q <= 1'b1;
            end
         end
      end
   end

   assign cmd_rdata_o = {ie_q, rww_q, 1'b0, reen_q, lock_q, write_q, erase_q, en_q};
   assign op_start_o  = start_q;
   assign op_kind_o   = kind_q;
   assign op_done_o   = tm_done;
   assign rww_busy_o  = rww_q;
   assign buf_load_o  = buf_q;
   assign lock_rd_o   = lrd_q;

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= ie_q & ~en_q;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = ie_q & ~en_q;
      end
   endgenerate

   AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> $past(store_i && !ee_busy_i)); // R6
   AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> ($countones(kind_q) == 1)); // R8
   AST_EN_DURING_OP: assert property (@(posedge clk) disable iff (!rst_n)
      tm_busy |-> en_q); // R7
   AST_RWW_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rww_q) |-> $past(store_i && reen_q && en_q && !ee_busy_i)); // R5
   AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (tm_busy && !tm_last) |=> ($stable(cmd_rdata_o[4:0]) && $stable(ie_q))); // R10
   AST_ARM_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> !tm_busy); // R1
endmodule

// File: tb/spm_cmd_ctrl_bench.sv
module spm_cmd_ctrl_bench;
   localparam int OPC = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_wr = 1'b0;
   logic [7:0] cmd_wdata = 8'h00;
   logic store = 1'b0, load = 1'b0, ee = 1'b0;
   logic [7:0] rdata;
   logic op_start, op_done, rww, bufl, lrd, irq;
   logic [2:0] kind;

   int errors = 0;
   int checks = 0;
   int n_buf = 0, n_lrd = 0, n_start = 0, n_done = 0;
   int cycles = 0;

   // reference model state
   int m_en, m_er, m_wr, m_lk, m_re, m_ie, m_rww, m_age, m_busy, m_left;
   int m_start, m_done, m_buf, m_lrd, m_kind;

   always #4 clk = ~clk;

   spm_cmd_ctrl #(.CLK_KHZ(1000), .OP_US(OPC)) u_spm_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wdata),
      .cmd_rdata_o(rdata), .store_i(store), .load_i(load), .ee_busy_i(ee),
      .op_start_o(op_start), .op_kind_o(kind), .op_done_o(op_done),
      .rww_busy_o(rww), .buf_load_o(bufl), .lock_rd_o(lrd), .irq_o(irq)
   );

   task automatic expect_eq(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic model_clear();
      m_en = 0; m_er = 0; m_wr = 0; m_lk = 0; m_re = 0;
   endtask

   task automatic model_step();
      bit acc_s, acc_l;
      int n;
      m_start = 0; m_done = 0; m_buf = 0; m_lrd = 0;
      if (m_busy != 0) begin
         if (m_left == 0) begin
            m_busy = 0; m_done = 1; model_clear();
         end else m_left--;
      end else begin
         acc_s = (m_age > 0) && store && !ee;
         acc_l = !acc_s && (m_age > 0) && (m_lk != 0) && load && !ee && (m_age <= 3);
         if (acc_s) begin
            n = m_er + m_wr + m_lk + m_re;
            m_age = 0;
            if (n > 1) model_clear();
            else if (m_er + m_wr + m_lk == 1) begin
               m_busy = 1; m_left = OPC - 1; m_start = 1;
               m_kind = (m_er != 0) ? 1 : ((m_wr != 0) ? 2 : 4);
               if (m_er + m_wr != 0) m_rww = 1;
            end else if (m_re != 0) begin
               m_rww = 0; model_clear();
            end else begin
               m_buf = 1; model_clear();
            end
         end else if (acc_l) begin
            m_lrd = 1; model_clear(); m_age = 0;
         end else if (cmd_wr) begin
            m_en = cmd_wdata[0]; m_er = cmd_wdata[1]; m_wr = cmd_wdata[2];
            m_lk = cmd_wdata[3]; m_re = cmd_wdata[4]; m_ie = cmd_wdata[7];
            m_age = cmd_wdata[0] ? 1 : 0;
         end else if (m_age > 0) begin
            if (m_age == 4) begin model_clear(); m_age = 0; end
            else m_age++;
         end
      end
   endtask

   task automatic compare();
      int exp_rd;
      exp_rd = (m_ie << 7) | (m_rww << 6) | (m_re << 4) | (m_lk << 3) | (m_wr << 2) | (m_er << 1) | m_en;
      expect_eq("R11 rdata", int'(rdata), exp_rd);
      expect_eq("R9 irq", int'(irq), (m_ie != 0 && m_en == 0) ? 1 : 0);
      expect_eq("R4 op_start", int'(op_start), m_start);
      if (m_start != 0) expect_eq("R4 op_kind", int'(kind), m_kind);
      expect_eq("R5 rww_busy", int'(rww), m_rww);
      expect_eq("R7 op_done", int'(op_done), m_done);
      expect_eq("R1 buf_load", int'(bufl), m_buf);
      expect_eq("R2 lock_rd", int'(lrd), m_lrd);
      n_buf += int'(bufl); n_lrd += int'(lrd); n_start += int'(op_start); n_done += int'(op_done);
   endtask

   task automatic cyc(input logic w, input logic [7:0] d, input logic s, input logic l, input logic e);
      cmd_wr = w; cmd_wdata = d; store = s; load = l; ee = e;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
      cmd_wr = 1'b0; store = 1'b0; load = 1'b0; ee = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got %0d cycles expected completion", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int b;
      m_ie = 0; m_rww = 0; m_age = 0; m_busy = 0; m_left = 0; m_kind = 0;
      m_start = 0; m_done = 0; m_buf = 0; m_lrd = 0;
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare();
      expect_eq("R11 reset rdata", int'(rdata), 0);

      // R1: store on the last window cycle is accepted
      b = n_buf;
      cyc(1'b1, 8'h81, 0, 0, 0); idle(3); cyc(0, 8'h00, 1, 0, 0); idle(1);
      expect_eq("R1 store at age 4", n_buf - b, 1);
      expect_eq("R9 irq after clear", int'(irq), 1);

      // R1/R3: store one cycle late is ignored, command expires
      b = n_buf;
      cyc(1'b1, 8'h01, 0, 0, 0); idle(4);
      expect_eq("R3 expired bits", int'(rdata[4:0]), 0);
      cyc(0, 8'h00, 1, 0, 0); idle(1);
      expect_eq("R1 late store ignored", n_buf - b, 0);

      // R2: load window
      b = n_lrd;
      cyc(1'b1, 8'h09, 0, 0, 0); idle(2); cyc(0, 8'h00, 0, 1, 0); idle(1);
      expect_eq("R2 load at age 3", n_lrd - b, 1);
      b = n_lrd;
      cyc(1'b1, 8'h09, 0, 0, 0); idle(3); cyc(0, 8'h00, 0, 1, 0); idle(1);
      expect_eq("R2 load at age 4 ignored", n_lrd - b, 0);
      b = n_lrd;
      cyc(1'b1, 8'h01, 0, 0, 0); cyc(0, 8'h00, 0, 1, 0); idle(5);
      expect_eq("R2 load without lock-select", n_lrd - b, 0);

      // R4/R7/R10/R5: page erase
      b = n_start;
      cyc(1'b1, 8'h83, 0, 0, 0); cyc(0, 8'h00, 1, 0, 0);
      expect_eq("R4 erase start", n_start - b, 1);
      expect_eq("R4 erase kind", int'(kind), 1);
      expect_eq("R4 rww set", int'(rww), 1);
      idle(3);
      cyc(1'b1, 8'h01, 0, 0, 0);
      expect_eq("R10 write ignored", int'(rdata), 8'hC3);
      expect_eq("R9 irq low while busy", int'(irq), 0);
      b = n_done;
      idle(OPC);
      expect_eq("R7 done once", n_done - b, 1);
      expect_eq("R7 en cleared", int'(rdata[0]), 0);
      expect_eq("R5 rww persists", int'(rww), 1);
      idle(3);
      expect_eq("R5 rww still set", int'(rww), 1);

      // R5: re-enable
      cyc(1'b1, 8'h11, 0, 0, 0); cyc(0, 8'h00, 1, 0, 0);
      expect_eq("R5 rww cleared", int'(rww), 0);

      // R4: page write
      cyc(1'b1, 8'h05, 0, 0, 0); idle(1); cyc(0, 8'h00, 1, 0, 0);
      expect_eq("R4 write kind", int'(kind), 2);
      idle(OPC + 1);
      cyc(1'b1, 8'h11, 0, 0, 0); cyc(0, 8'h00, 1, 0, 0);

      // R8: invalid combination
      b = n_start;
      cyc(1'b1, 8'h07, 0, 0, 0); cyc(0, 8'h00, 1, 0, 0); idle(2);
      expect_eq("R8 no start", n_start - b, 0);
      expect_eq("R8 bits cleared", int'(rdata[4:0]), 0);
      expect_eq("R8 rww unchanged", int'(rww), 0);

      // R6: EEPROM write refuses strobe, window continues
      b = n_start;
      cyc(1'b1, 8'h03, 0, 0, 0); cyc(0, 8'h00, 1, 0, 1);
      expect_eq("R6 refused store", n_start - b, 0);
      cyc(0, 8'h00, 1, 0, 0);
      expect_eq("R6 later store accepted", n_start - b, 1);
      idle(OPC + 1);
      cyc(1'b1, 8'h11, 0, 0, 0); cyc(0, 8'h00, 1, 0, 0);
      b = n_lrd;
      cyc(1'b1, 8'h09, 0, 0, 0); cyc(0, 8'h00, 0, 1, 1); idle(4);
      expect_eq("R6 refused load", n_lrd - b, 0);

      // R12: lock-bit write
      b = n_start;
      cyc(1'b1, 8'h09, 0, 0, 0); cyc(0, 8'h00, 1, 0, 0);
      expect_eq("R12 lock start", n_start - b, 1);
      expect_eq("R12 lock kind", int'(kind), 4);
      expect_eq("R12 rww unchanged", int'(rww), 0);
      idle(OPC + 2);
      expect_eq("R7 lock done", int'(rdata[0]), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule